// File: doc/BRIEF.md
# Integer Multiply Result Unit

This block computes the product-based results of the standard integer multiply extension for a core with 32-bit registers. It takes both source register values together with the function fields of a register-register arithmetic instruction, and in the same cycle returns one 32-bit result word. That word is either the low half of the full product or its high half. The high half can be computed with both operands signed, with both unsigned, or with the first signed and the second unsigned.

Internally, each operand is widened by one bit. The bit is a copy of the sign bit when that operand is treated as signed, and zero when it is treated as unsigned. A single signed multiply of the two widened values then serves every variant, and the 32-bit slice the instruction asks for is taken from its result. A parameter chooses how that multiply is built: a plain multiply operator, or an explicit array of shifted partial rows. The unit raises a claim flag only for encodings it owns. For every other encoding it holds its result at zero, so the core can OR it into a shared writeback path.

Top module: `mulu_rv32m`

## Requirements
- R1: `res_claim` is 1 exactly when `op_is_reg` is 1, `grp_code` equals 7'b0000001 and `sel_code[2]` is 0; otherwise it is 0.
- R2: Whenever `res_claim` is 0, `res_word` is 32'h0 regardless of the operands.
- R3: With `sel_code` = 3'b000 and a claim, `res_word` is bits [31:0] of `src_a` × `src_b`; this value is the same under signed and unsigned reading of the operands.
- R4: With `sel_code` = 3'b001 and a claim, `res_word` is bits [63:32] of the product of signed `src_a` and signed `src_b`.
- R5: With `sel_code` = 3'b010 and a claim, `res_word` is bits [63:32] of the product of signed `src_a` and unsigned `src_b`.
- R6: With `sel_code` = 3'b011 and a claim, `res_word` is bits [63:32] of the product of unsigned `src_a` and unsigned `src_b`.
- R7: The unit holds no state, and `res_word` follows a change on any input without any clock edge in between.
- R8: With `grp_code` = 7'b0000001 and `op_is_reg` = 1, any `sel_code` from 3'b100 to 3'b111 gives `res_claim` = 0 and `res_word` = 0, even for operands with a nonzero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_is_reg | input | 1 | Current instruction is a register-register arithmetic operation |
| grp_code | input | 7 | Upper function field of the instruction |
| sel_code | input | 3 | Lower function field, picks the product half and signedness |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| res_word | output | 32 | Selected product word, zero when not claimed |
| res_claim | output | 1 | Unit owns this instruction encoding |

## Verification
Within one input pattern, the ownership decode and the product selection act together. An operand pair with a large nonzero product can arrive along with a select that has its top bit set, a wrong upper function field, or a low instruction-type flag, and only the decode decides whether that product reaches the output. The randomized stimulus makes such mixed patterns often, and directed cases pair the extreme operands with each rejected select. The bench then checks the low claim and the zero word against a model that computes ownership and the 64-bit products on its own. The extreme operand pairs are 0x80000000 squared, all-ones times all-ones, and the signed minus-one times unsigned all-ones case. Each of them also runs under all four valid selects, where the signedness of each operand changes the high word.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

   // lower function field values owned by the unit
   typedef enum logic [2:0] {
      SEL_LO    = 3'b000,
      SEL_HI_SS = 3'b001,
      SEL_HI_SU = 3'b010,
      SEL_HI_UU = 3'b011
   } mul_sel_e;

   localparam logic [6:0] GROUP_MULDIV = 7'b0000001;

   // operand signedness for a given select
   function automatic logic sel_a_signed(input logic [2:0] sel);
      return (sel == SEL_HI_SS) || (sel == SEL_HI_SU);
   endfunction

   function automatic logic sel_b_signed(input logic [2:0] sel);
      return (sel == SEL_HI_SS);
   endfunction

endpackage

// File: rtl/mulu_opnd_ext.sv
module mulu_opnd_ext #(
   parameter int W = 32
) (
   input  logic [W-1:0] val,
   input  logic         as_signed,
   output logic [W:0]   ext
);

   generate
      if (W < 2) begin : g_bad_w
         $error("mulu_opnd_ext: W must be at least 2");
      end
   endgenerate

   logic top_bit;

   always_comb begin
      top_bit = as_signed & val[W-1];
      ext     = {top_bit, val};
   end

endmodule

// File: rtl/mulu_prod_core.sv
module mulu_prod_core #(
   parameter int W         = 32,
   parameter bit USE_ARRAY = 1'b1,
   localparam int EW = W + 1,
   localparam int PW = 2 * EW
) (
   input  logic [EW-1:0] a_ext,
   input  logic [EW-1:0] b_ext,
   output logic [PW-1:0] prod
);

   generate
      if (W < 2) begin : g_bad_w
         $error("mulu_prod_core: W must be at least 2");
      end
   endgenerate

   logic signed [PW-1:0] a_wide;
   logic signed [PW-1:0] b_wide;

   always_comb begin
      a_wide = {{EW{a_ext[EW-1]}}, a_ext};
      b_wide = {{EW{b_ext[EW-1]}}, b_ext};
   end

   generate
      if (USE_ARRAY) begin : g_array
         // rows for the magnitude bits of b, then the weight -2^W for its top bit
         logic [PW-1:0] acc [0:W];
         logic [PW-1:0] top_row;

         assign acc[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_row
            logic [PW-1:0] row;
            assign row      = b_ext[i] ? (PW'(a_wide) << i) : '0;
            assign acc[i+1] = acc[i] + row;
         end
         assign top_row = b_ext[EW-1] ? (PW'(a_wide) << W) : '0;
         assign prod    = acc[W] - top_row;
      end else begin : g_direct
         logic signed [PW-1:0] full;
         assign full = a_wide * b_wide;
         assign prod = full;
      end
   endgenerate

   // zero operand gives zero product
   always_comb begin
      if ((a_ext == '0) || (b_ext == '0))
         p_zero_operand_r3 : assert (prod == '0);
   end

   // sign of a nonzero product follows the operand signs
   always_comb begin
      if ((a_ext != '0) && (b_ext != '0))
         p_prod_sign_r4 : assert (prod[PW-1] == (a_ext[EW-1] ^ b_ext[EW-1]));
   end

endmodule

// File: rtl/mulu_res_sel.sv
module mulu_res_sel
   import mulu_pkg::*;
#(
   parameter int W = 32,
   localparam int PW = 2 * (W + 1)
) (
   input  logic [PW-1:0] prod,
   input  logic [2:0]    sel,
   input  logic          claim,
   output logic [W-1:0]  res
);

   logic [W-1:0] lo_word;
   logic [W-1:0] hi_word;

   always_comb begin
      lo_word = prod[W-1:0];
      hi_word = prod[2*W-1:W];
      res     = '0;
      if (claim) begin
         if (sel == SEL_LO) res = lo_word;
         else               res = hi_word;
      end
   end

endmodule

// File: rtl/mulu_rv32m.sv
module mulu_rv32m
   import mulu_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit USE_ARRAY = 1'b1,
   localparam int PW = 2 * (XLEN + 1)
) (
   input  logic            op_is_reg,
   input  logic [6:0]      grp_code,
   input  logic [2:0]      sel_code,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic [XLEN-1:0] res_word,
   output logic            res_claim
);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("mulu_rv32m: XLEN must be at least 8");
      end
   endgenerate

   logic            a_sgn;
   logic            b_sgn;
   logic [XLEN:0]   a_ext;
   logic [XLEN:0]   b_ext;
   logic [PW-1:0]   prod;

   always_comb begin
      res_claim = op_is_reg && (grp_code == GROUP_MULDIV) && !sel_code[2];
      a_sgn     = sel_a_signed(sel_code);
      b_sgn     = sel_b_signed(sel_code);
   end

   mulu_opnd_ext #(.W(XLEN)) u_ext_a (
      .val(src_a), .as_signed(a_sgn), .ext(a_ext)
   );

   mulu_opnd_ext #(.W(XLEN)) u_ext_b (
      .val(src_b), .as_signed(b_sgn), .ext(b_ext)
   );

   mulu_prod_core #(.W(XLEN), .USE_ARRAY(USE_ARRAY)) u_core (
      .a_ext(a_ext), .b_ext(b_ext), .prod(prod)
   );

   mulu_res_sel #(.W(XLEN)) u_sel (
      .prod(prod), .sel(sel_code), .claim(res_claim), .res(res_word)
   );

   // claim only for the multiply/divide group
   always_comb begin
      if (res_claim)
         p_claim_group_r1 : assert (grp_code == GROUP_MULDIV && op_is_reg);
   end

   // nothing leaks onto the shared result path
   always_comb begin
      if (!res_claim)
         p_zero_unclaimed_r2 : assert (res_word == '0);
   end

   // high half of two non-negative signed operands is non-negative
   always_comb begin
      if (res_claim && sel_code == SEL_HI_SS && !src_a[XLEN-1] && !src_b[XLEN-1])
         p_mulh_nonneg_r4 : assert (!res_word[XLEN-1]);
   end

   // unsigned high half of a zero operand is zero
   always_comb begin
      if (res_claim && sel_code == SEL_HI_UU && (src_a == '0 || src_b == '0))
         p_mulhu_zero_r6 : assert (res_word == '0);
   end

   // top select bit never claims
   always_comb begin
      if (sel_code[2])
         p_upper_sel_r8 : assert (!res_claim);
   end

endmodule

// File: tb/mulu_rv32m_tb_top.sv
`timescale 1ns/1ps
module mulu_rv32m_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_is_reg;
   logic [6:0]  grp_code;
   logic [2:0]  sel_code;
   logic [31:0] src_a;
   logic [31:0] src_b;
   logic [31:0] res_word;
   logic        res_claim;

   int n_cmp = 0;
   int n_mis = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   mulu_rv32m dut_i (
      .op_is_reg(op_is_reg), .grp_code(grp_code), .sel_code(sel_code),
      .src_a(src_a), .src_b(src_b), .res_word(res_word), .res_claim(res_claim)
   );

   function automatic logic model_claim(logic isop, logic [6:0] grp, logic [2:0] sel);
      return isop && grp == 7'b0000001 && sel[2] == 1'b0;
   endfunction

   function automatic logic [31:0] model_res(logic isop, logic [6:0] grp, logic [2:0] sel,
                                             logic [31:0] a, logic [31:0] b);
      longint      ss;
      longint      su;
      logic [63:0] uu;
      if (!model_claim(isop, grp, sel)) return 32'h0;
      ss = longint'($signed(a)) * longint'($signed(b));
      su = longint'($signed(a)) * longint'({32'h0, b});
      uu = {32'h0, a} * {32'h0, b};
      case (sel)
         3'b000:  return uu[31:0];
         3'b001:  return ss[63:32];
         3'b010:  return su[63:32];
         default: return uu[63:32];
      endcase
   endfunction

   function automatic string req_of(logic isop, logic [6:0] grp, logic [2:0] sel);
      if (!model_claim(isop, grp, sel)) return (isop && grp == 7'b0000001) ? "R8" : "R2";
      case (sel)
         3'b000:  return "R3";
         3'b001:  return "R4";
         3'b010:  return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // drive after the falling edge, sample 1 ns later with no clock edge between (R7)
   task automatic apply(logic isop, logic [6:0] grp, logic [2:0] sel,
                        logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      op_is_reg = isop; grp_code = grp; sel_code = sel; src_a = a; src_b = b;
      #1;
      chk("R1 claim", {31'h0, res_claim}, {31'h0, model_claim(isop, grp, sel)});
      chk(req_of(isop, grp, sel), res_word, model_res(isop, grp, sel, a, b));
   endtask

   task automatic lit(logic [2:0] sel, logic [31:0] a, logic [31:0] b,
                      string req, logic [31:0] exp);
      @(negedge clk);
      op_is_reg = 1'b1; grp_code = 7'b0000001; sel_code = sel; src_a = a; src_b = b;
      #1;
      chk(req, res_word, exp);
   endtask

   initial begin
      op_is_reg = 1'b0; grp_code = 7'h0; sel_code = 3'h0;
      src_a = 32'hDEADBEEF; src_b = 32'h12345678;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // reset state: not an owned instruction, word held at zero
      chk("R2 idle word", res_word, 32'h0);
      chk("R1 idle claim", {31'h0, res_claim}, 32'h0);

      // literal corner values, each under every select
      lit(3'b000, 32'h80000000, 32'h80000000, "R3", 32'h00000000);
      lit(3'b001, 32'h80000000, 32'h80000000, "R4", 32'h40000000);
      lit(3'b010, 32'h80000000, 32'h80000000, "R5", 32'hC0000000);
      lit(3'b011, 32'h80000000, 32'h80000000, "R6", 32'h40000000);
      lit(3'b000, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3", 32'h00000001);
      lit(3'b001, 32'hFFFFFFFF, 32'hFFFFFFFF, "R4", 32'h00000000);
      lit(3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, "R5", 32'hFFFFFFFF);
      lit(3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, "R6", 32'hFFFFFFFE);
      lit(3'b010, 32'h00000002, 32'hFFFFFFFF, "R5", 32'h00000001);
      lit(3'b001, 32'h7FFFFFFF, 32'h80000000, "R4", 32'hC0000000);

      // rejected selects with a large product (R8), wrong group and flag (R2)
      for (int s = 4; s < 8; s++) begin
         apply(1'b1, 7'b0000001, 3'(s), 32'hFFFFFFFF, 32'h80000000);
      end
      apply(1'b1, 7'b0000000, 3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF);
      apply(1'b1, 7'b0100000, 3'b001, 32'h80000000, 32'h80000000);
      apply(1'b0, 7'b0000001, 3'b000, 32'h12345678, 32'h9ABCDEF0);

      // R7: change only operands, result follows without clock edge
      apply(1'b1, 7'b0000001, 3'b000, 32'h00010000, 32'h00010000);
      src_a = 32'h00000003; #0.5;
      chk("R7 follow", res_word, 32'h00030000);

      // constrained random
      void'($urandom(32'h5EED1234));
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] a;
         logic [31:0] b;
         logic [6:0]  g;
         logic        isop;
         int          pick;
         pick = int'($urandom_range(0, 9));
         a = $urandom();
         b = $urandom();
         if (pick == 0) a = 32'h80000000;
         if (pick == 1) b = 32'hFFFFFFFF;
         if (pick == 2) a = 32'h0;
         g    = ($urandom_range(0, 3) != 0) ? 7'b0000001 : 7'($urandom());
         isop = ($urandom_range(0, 7) != 0);
         apply(isop, g, 3'($urandom_range(0, 7)), a, b);
      end

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_mis++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

endmodule